// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block performs one accumulator-style arithmetic or logic operation per cycle on an 8-bit accumulator operand and an 8-bit second operand. The arithmetic, rotate and adjust operations read the incoming carry and auxiliary-carry bits. The result and the per-operation flag-change mask are produced combinationally. The five status flags (sign, zero, auxiliary carry, parity, carry) are held in a register. When an operation is issued, that register takes the new values of exactly the flags the operation is defined to change, and keeps all the others.

A surrounding datapath presents the operands and a 4-bit operation code, raises `opValid` for one cycle, writes `resultOut` back to its accumulator when `resultWr` is high, and reads the packed flag byte after the clock edge. Compare computes the flags of a subtraction but leaves the accumulator untouched. The complement and carry-only operations change at most one flag.

Top module: `aluFlagUnit`

## Requirements
- R1: Code 0 (add) and code 1 (add with carry) return accIn+oprIn (+cyIn for code 1) modulo 256, with CY = carry out of bit 7 and AC = carry out of bit 3 into bit 4; all five flags change and resultWr is 1.
- R2: Code 2 (subtract) and code 3 (subtract with borrow, cyIn taken as the borrow) return accIn-oprIn(-cyIn) modulo 256, with CY = 1 on a borrow; AC is the carry out of bit 3 of accIn + ~oprIn + (1, or 1-cyIn for code 3); all five flags change.
- R3: Code 4 (compare) sets flags as subtraction (CY when accIn < oprIn, Z when equal, both clear when accIn is greater) while resultWr is 0 and resultOut equals accIn.
- R4: For every operation whose mask includes them, S is bit 7 of the computed value, Z is 1 when it is zero, and P is 1 when it holds an even number of ones.
- R5: Code 5 (AND) sets AC and clears CY; code 6 (XOR) and code 7 (OR) clear both AC and CY; all three change S, Z and P.
- R6: Codes 8, 9, 10, 11 rotate left, rotate right, rotate left through carry, and rotate right through carry. The bit leaving the accumulator goes to CY; the plain rotates put it in the vacated bit, and the through-carry rotates put the old cyIn there. The mask is CY only (5'b00001).
- R7: Code 12 (decimal adjust) adds 6 when the low nibble exceeds 9 or acIn is 1. It then adds 0x60 when the high nibble of that intermediate sum exceeds 9 or cyIn is 1. CY = cyIn OR a carry out of bit 7 from either step; AC = carry out of the low-nibble step; all five flags change.
- R8: Code 13 returns ~accIn with an all-zero mask, so the flag byte does not change.
- R9: Code 14 sets CY and code 15 sets CY to ~cyIn; the mask is CY only, resultWr is 0 and resultOut equals accIn.
- R10: flagByte packs S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and CY in bit 0. Bits 5 and 3 read 0 and bit 1 reads 1, so after reset the byte is 0x02. flagMask orders the flags {S,Z,AC,P,CY} from bit 4 down to bit 0. At a rising edge with opValid high, only the masked flags take new values; with opValid low the byte does not change whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the flag register |
| opValid | input | 1 | Issues the presented operation at the next rising edge |
| opCode | input | 4 | Operation select, codes 0 to 15 |
| accIn | input | 8 | Accumulator operand |
| oprIn | input | 8 | Second operand |
| cyIn | input | 1 | Incoming carry or borrow |
| acIn | input | 1 | Incoming auxiliary carry, used by decimal adjust |
| resultOut | output | 8 | Operation result, accIn when not written |
| resultWr | output | 1 | High when the operation writes the accumulator |
| flagMask | output | 5 | Flags the operation changes, {S,Z,AC,P,CY} |
| flagByte | output | 8 | Registered packed flag byte |

## Verification
The bench builds the unit with its default 8-bit data width, and so with 4-bit nibbles. At that width the full operand space is small enough to cover completely. Every accumulator and operand pair passes through add or add-with-carry, and every accumulator value passes through decimal adjust under all four combinations of incoming carry and auxiliary carry. This covers every nibble-overflow and double-correction case. Directed cases fix the compare orderings, the rotates and the complement operations, and randomized operations interleaved with idle cycles show that masked and idle flags hold.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_N  = 5;
  localparam int OPC_W   = 4;
  localparam int FBYTE_W = 8;

  // flag index inside flagMask and the flag vector
  localparam int F_CY = 0;
  localparam int F_P  = 1;
  localparam int F_AC = 2;
  localparam int F_Z  = 3;
  localparam int F_S  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_XOR = 4'd6,  OP_OR  = 4'd7,
    OP_RLC = 4'd8,  OP_RRC = 4'd9,  OP_RAL = 4'd10, OP_RAR = 4'd11,
    OP_DAA = 4'd12, OP_CMA = 4'd13, OP_STC = 4'd14, OP_CMC = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    U_ARITH, U_LOGIC, U_ROT, U_DAA, U_CMA, U_CARRY
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    unit_e      unitSel;
    logic       invOpr;    // subtract path: invert operand
    logic       useCarry;  // fold cyIn into the adder
    logic [1:0] subSel;    // variant inside the selected unit
    logic       wrRes;     // result goes to the accumulator
  } aluStrobe_t;

  localparam logic [FLAG_N-1:0] MASK_ALL  = 5'b11111;
  localparam logic [FLAG_N-1:0] MASK_CY   = 5'b00001;
  localparam logic [FLAG_N-1:0] MASK_NONE = 5'b00000;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [OPC_W-1:0]  opCode,
  output aluStrobe_t        strobe,
  output logic [FLAG_N-1:0] flagMask
);
  always_comb begin
    strobe.unitSel  = U_ARITH;
    strobe.invOpr   = 1'b0;
    strobe.useCarry = 1'b0;
    strobe.subSel   = 2'd0;
    strobe.wrRes    = 1'b1;
    flagMask        = MASK_ALL;
    unique case (aluOp_e'(opCode))
      OP_ADD: ;
      OP_ADC: strobe.useCarry = 1'b1;
      OP_SUB: strobe.invOpr = 1'b1;
      OP_SBB: begin strobe.invOpr = 1'b1; strobe.useCarry = 1'b1; end
      OP_CMP: begin strobe.invOpr = 1'b1; strobe.wrRes = 1'b0; end
      OP_AND: begin strobe.unitSel = U_LOGIC; strobe.subSel = 2'd0; end
      OP_XOR: begin strobe.unitSel = U_LOGIC; strobe.subSel = 2'd1; end
      OP_OR:  begin strobe.unitSel = U_LOGIC; strobe.subSel = 2'd2; end
      OP_RLC: begin strobe.unitSel = U_ROT; strobe.subSel = 2'd0; flagMask = MASK_CY; end
      OP_RRC: begin strobe.unitSel = U_ROT; strobe.subSel = 2'd1; flagMask = MASK_CY; end
      OP_RAL: begin strobe.unitSel = U_ROT; strobe.subSel = 2'd2; flagMask = MASK_CY; end
      OP_RAR: begin strobe.unitSel = U_ROT; strobe.subSel = 2'd3; flagMask = MASK_CY; end
      OP_DAA: strobe.unitSel = U_DAA;
      OP_CMA: begin strobe.unitSel = U_CMA; flagMask = MASK_NONE; end
      OP_STC: begin
        strobe.unitSel = U_CARRY; strobe.subSel = 2'd0;
        strobe.wrRes = 1'b0; flagMask = MASK_CY;
      end
      OP_CMC: begin
        strobe.unitSel = U_CARRY; strobe.subSel = 2'd1;
        strobe.wrRes = 1'b0; flagMask = MASK_CY;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DW = DATA_W
)(
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     oprIn,
  input  logic              cyIn,
  input  logic              acIn,
  input  aluStrobe_t        strobe,
  output logic [DW-1:0]     resultOut,
  output logic [FLAG_N-1:0] flagsNew
);
  localparam int NIB_W = DW / 2;
  localparam logic [NIB_W-1:0] DEC_MAX  = NIB_W'(9);
  localparam logic [NIB_W:0]   NIB_FIX  = (NIB_W+1)'(6);
  localparam logic [DW:0]      LOW_FIX  = (DW+1)'(6);
  localparam logic [DW:0]      HIGH_FIX = (DW+1)'(6) << NIB_W;

  // shared adder: add, add with carry, subtract, borrow, compare
  logic [DW-1:0] opB;
  logic          cin;
  logic [DW:0]   sumFull;
  logic [NIB_W:0] lowSum;

  assign opB     = strobe.invOpr ? ~oprIn : oprIn;
  assign cin     = strobe.invOpr ^ (strobe.useCarry & cyIn);
  assign sumFull = {1'b0, accIn} + {1'b0, opB} + {{DW{1'b0}}, cin};
  assign lowSum  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, opB[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};

  // bitwise unit
  logic [DW-1:0] logicRes;
  always_comb begin
    unique case (strobe.subSel)
      2'd0:    logicRes = accIn & oprIn;
      2'd1:    logicRes = accIn ^ oprIn;
      default: logicRes = accIn | oprIn;
    endcase
  end

  // rotate unit
  logic [DW-1:0] rotRes;
  logic          rotCy;
  always_comb begin
    unique case (strobe.subSel)
      2'd0: begin rotRes = {accIn[DW-2:0], accIn[DW-1]}; rotCy = accIn[DW-1]; end
      2'd1: begin rotRes = {accIn[0], accIn[DW-1:1]};    rotCy = accIn[0];    end
      2'd2: begin rotRes = {accIn[DW-2:0], cyIn};        rotCy = accIn[DW-1]; end
      default: begin rotRes = {cyIn, accIn[DW-1:1]};     rotCy = accIn[0];    end
    endcase
  end

  // decimal adjust: low correction, then high test on the corrected value
  logic           lowFix, hiFix;
  logic [NIB_W:0] lowStep;
  logic [DW:0]    stage1, stage2;
  logic           daaCy;

  assign lowFix  = (accIn[NIB_W-1:0] > DEC_MAX) || acIn;
  assign lowStep = {1'b0, accIn[NIB_W-1:0]} + (lowFix ? NIB_FIX : '0);
  assign stage1  = {1'b0, accIn} + (lowFix ? LOW_FIX : '0);
  assign hiFix   = (stage1[DW-1:NIB_W] > DEC_MAX) || cyIn;
  assign stage2  = {1'b0, stage1[DW-1:0]} + (hiFix ? HIGH_FIX : '0);
  assign daaCy   = cyIn | stage1[DW] | stage2[DW];

  // unit select and flag formation
  logic [DW-1:0] rawRes;
  logic          newCy, newAc;
  always_comb begin
    rawRes = sumFull[DW-1:0];
    newCy  = sumFull[DW] ^ strobe.invOpr;
    newAc  = lowSum[NIB_W];
    unique case (strobe.unitSel)
      U_LOGIC: begin
        rawRes = logicRes;
        newCy  = 1'b0;
        newAc  = (strobe.subSel == 2'd0);
      end
      U_ROT: begin rawRes = rotRes; newCy = rotCy; newAc = acIn; end
      U_DAA: begin rawRes = stage2[DW-1:0]; newCy = daaCy; newAc = lowStep[NIB_W]; end
      U_CMA: begin rawRes = ~accIn; newCy = cyIn; newAc = acIn; end
      U_CARRY: begin
        rawRes = accIn;
        newCy  = strobe.subSel[0] ? ~cyIn : 1'b1;
        newAc  = acIn;
      end
      default: ;
    endcase
  end

  assign resultOut = strobe.wrRes ? rawRes : accIn;
  assign flagsNew  = {rawRes[DW-1], ~|rawRes, newAc, ~^rawRes, newCy};
endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluPkg::*;
#(
  parameter int DW = DATA_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [OPC_W-1:0]   opCode,
  input  logic [DW-1:0]      accIn,
  input  logic [DW-1:0]      oprIn,
  input  logic               cyIn,
  input  logic               acIn,
  output logic [DW-1:0]      resultOut,
  output logic               resultWr,
  output logic [FLAG_N-1:0]  flagMask,
  output logic [FBYTE_W-1:0] flagByte
);
  aluStrobe_t        strobe;
  logic [FLAG_N-1:0] flagsNew;
  logic [FLAG_N-1:0] flagQ;

  aluControl uCtl (
    .opCode   (opCode),
    .strobe   (strobe),
    .flagMask (flagMask)
  );

  aluDatapath #(.DW(DW)) uDp (
    .accIn     (accIn),
    .oprIn     (oprIn),
    .cyIn      (cyIn),
    .acIn      (acIn),
    .strobe    (strobe),
    .resultOut (resultOut),
    .flagsNew  (flagsNew)
  );

  assign resultWr = strobe.wrRes;

  // one enable per flag, gated by the operation's mask
  for (genvar g = 0; g < FLAG_N; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     flagQ[g] <= 1'b0;
      else if (opValid && flagMask[g]) flagQ[g] <= flagsNew[g];
    end
  end

  assign flagByte = {flagQ[F_S], flagQ[F_Z], 1'b0, flagQ[F_AC],
                     1'b0, flagQ[F_P], 1'b1, flagQ[F_CY]};

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagByte));

  assert_unmasked_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && flagMask == '0) |=> $stable(flagByte));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && resultWr && flagMask[F_Z]) |=> (flagByte[6] == ($past(resultOut) == '0)));

  assert_sign_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && resultWr && flagMask[F_S]) |=> (flagByte[7] == $past(resultOut[DW-1])));

  assert_compare_nowrite_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |-> (!resultWr && resultOut == accIn));

  assert_and_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_AND) |=> (flagByte[4] && !flagByte[0]));

  assert_rotate_cy_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode[3:2] == 2'b10) |-> (flagMask == MASK_CY));

  assert_daa_carry_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_DAA && cyIn) |=> flagByte[0]);

  assert_cma_flags_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMA) |=> $stable(flagByte));

  assert_stc_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_STC) |=> flagByte[0]);
endmodule

// File: tb/tb_aluFlagUnit.sv
module tb_aluFlagUnit;
  import aluPkg::*;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] accIn = '0, oprIn = '0;
  logic       cyIn = 1'b0, acIn = 1'b0;
  logic [7:0] resultOut;
  logic       resultWr;
  logic [4:0] flagMask;
  logic [7:0] flagByte;

  int checkCount = 0;
  int errorCount = 0;
  logic [4:0] modelFlags = '0;   // {S,Z,AC,P,CY}

  typedef struct packed {
    logic       checkComb;
    logic [7:0] expRes;
    logic       expWr;
    logic [4:0] expMask;
    logic [7:0] expFlags;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aluFlagUnit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .oprIn(oprIn), .cyIn(cyIn), .acIn(acIn),
    .resultOut(resultOut), .resultWr(resultWr),
    .flagMask(flagMask), .flagByte(flagByte)
  );

  function automatic logic [7:0] packFlags(input logic [4:0] f);
    return {f[4], f[3], 1'b0, f[2], 1'b0, f[1], 1'b1, f[0]};
  endfunction

  // independent reference model built from the requirement text
  task automatic modelOp(input int op, input int a, input int b, input int ci, input int ai,
                         output int portRes, output bit wr, output logic [4:0] mask,
                         output logic [4:0] nf, output string tag);
    int r, cy, ac, d, lo, add1, t, hi, add2, u;
    logic [7:0] rb;
    r = a; cy = ci; ac = ai; wr = 1'b1; mask = 5'b11111; tag = "R1";
    case (op)
      0, 1: begin
        d  = (op == 1) ? ci : 0;
        r  = (a + b + d) % 256;
        cy = ((a + b + d) > 255) ? 1 : 0;
        ac = (((a % 16) + (b % 16) + d) > 15) ? 1 : 0;
      end
      2, 3, 4: begin
        d  = (op == 3) ? ci : 0;
        t  = a - b - d;
        cy = (t < 0) ? 1 : 0;
        r  = (t < 0) ? t + 256 : t;
        ac = (((a % 16) + (15 - (b % 16)) + (1 - d)) > 15) ? 1 : 0;
        tag = (op == 4) ? "R3" : "R2";
        wr  = (op != 4);
      end
      5: begin r = a & b; cy = 0; ac = 1; tag = "R5"; end
      6: begin r = a ^ b; cy = 0; ac = 0; tag = "R5"; end
      7: begin r = a | b; cy = 0; ac = 0; tag = "R5"; end
      8:  begin r = ((a * 2) % 256) + (a / 128); cy = a / 128; mask = 5'b00001; tag = "R6"; end
      9:  begin r = (a / 2) + (a % 2) * 128;     cy = a % 2;   mask = 5'b00001; tag = "R6"; end
      10: begin r = ((a * 2) % 256) + ci;        cy = a / 128; mask = 5'b00001; tag = "R6"; end
      11: begin r = (a / 2) + ci * 128;          cy = a % 2;   mask = 5'b00001; tag = "R6"; end
      12: begin
        lo   = a % 16;
        add1 = (lo > 9 || ai != 0) ? 6 : 0;
        t    = a + add1;
        ac   = ((lo + add1) > 15) ? 1 : 0;
        hi   = (t / 16) % 16;
        add2 = (hi > 9 || ci != 0) ? 96 : 0;
        u    = (t % 256) + add2;
        cy   = (ci != 0 || t > 255 || u > 255) ? 1 : 0;
        r    = u % 256;
        tag  = "R7";
      end
      13: begin r = 255 - a; mask = 5'b00000; tag = "R8"; end
      14: begin cy = 1;      mask = 5'b00001; wr = 1'b0; tag = "R9"; end
      default: begin cy = 1 - ci; mask = 5'b00001; wr = 1'b0; tag = "R9"; end
    endcase
    rb = 8'(r);
    nf = {rb[7], (rb == 8'h00), 1'(ac), ~^rb, 1'(cy)};
    portRes = wr ? r : a;
  endtask

  task automatic doOp(input int op, input int a, input int b, input int ci, input int ai,
                      input string tagOverride);
    int pr; bit wr; logic [4:0] mask, nf; string tg;
    expItem_t it;
    @(negedge clk);
    opValid = 1'b1; opCode = 4'(op); accIn = 8'(a); oprIn = 8'(b);
    cyIn = 1'(ci); acIn = 1'(ai);
    modelOp(op, a, b, ci, ai, pr, wr, mask, nf, tg);
    modelFlags = (modelFlags & ~mask) | (nf & mask);
    it.checkComb = 1'b1; it.expRes = 8'(pr); it.expWr = wr;
    it.expMask = mask; it.expFlags = packFlags(modelFlags);
    expQ.push_back(it);
    tagQ.push_back((tagOverride != "") ? tagOverride : tg);
  endtask

  // R10: idle cycle with disturbed inputs, flags must hold
  task automatic idleCheck();
    expItem_t it;
    @(negedge clk);
    opValid = 1'b0; opCode = 4'(OP_STC); accIn = 8'hA5; oprIn = 8'h5A;
    cyIn = ~cyIn; acIn = ~acIn;
    it = '0;
    it.expFlags = packFlags(modelFlags);
    expQ.push_back(it);
    tagQ.push_back("R10");
  endtask

  // monitor: pop one expectation per issued cycle, after the edge
  initial begin
    expItem_t it; string tg; logic ok;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        tg = tagQ.pop_front();
        checkCount++;
        ok = (flagByte == it.expFlags);
        if (it.checkComb)
          ok = ok && (resultOut == it.expRes) && (resultWr == it.expWr) && (flagMask == it.expMask);
        if (!ok) begin
          errorCount++;
          $display("FAIL %s: actual res=%h wr=%b mask=%b flags=%h expected res=%h wr=%b mask=%b flags=%h",
                   tg, resultOut, resultWr, flagMask, flagByte,
                   it.expRes, it.expWr, it.expMask, it.expFlags);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errorCount, checkCount);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errorCount++; checkCount++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    finishRun();
  end

  task automatic directCheck(input string tg, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      errorCount++;
      $display("FAIL %s: actual=%h expected=%h", tg, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    directCheck("R10 in reset", flagByte, 8'h02);
    rstN = 1'b1;
    @(negedge clk); #1;
    directCheck("R10 after reset", flagByte, 8'h02);

    // R1 corner cases
    doOp(0, 8'hFF, 8'h01, 0, 0, "R1");
    doOp(1, 8'h3A, 8'h05, 1, 0, "R1");
    doOp(0, 8'h70, 8'h10, 1, 0, "R1");
    // R4 parity and sign
    doOp(0, 8'h01, 8'h02, 0, 0, "R4");
    doOp(6, 8'h03, 8'h04, 0, 0, "R4");
    // R2 borrow cases
    doOp(2, 8'h05, 8'h06, 0, 0, "R2");
    doOp(3, 8'h10, 8'h0F, 1, 0, "R2");
    doOp(3, 8'h00, 8'h00, 1, 0, "R2");
    // R3 compare orderings
    doOp(4, 8'h42, 8'h42, 0, 0, "R3");
    doOp(4, 8'h10, 8'h80, 0, 0, "R3");
    doOp(4, 8'h90, 8'h20, 1, 0, "R3");
    // R5 logic
    doOp(5, 8'hF0, 8'h3C, 1, 0, "R5");
    doOp(7, 8'h00, 8'h00, 1, 1, "R5");
    doOp(6, 8'hFF, 8'h0F, 1, 1, "R5");
    // R6 rotates
    doOp(8, 8'h81, 0, 0, 0, "R6");
    doOp(9, 8'h01, 0, 0, 0, "R6");
    doOp(10, 8'h40, 0, 1, 0, "R6");
    doOp(11, 8'h02, 0, 1, 0, "R6");
    // R7 decimal adjust
    doOp(12, 8'h9A, 0, 0, 0, "R7");
    doOp(12, 8'h15, 0, 0, 1, "R7");
    doOp(12, 8'h00, 0, 1, 0, "R7");
    doOp(12, 8'h99, 0, 0, 0, "R7");
    doOp(12, 8'hFA, 0, 0, 0, "R7");
    // R8 complement with flags set beforehand
    doOp(0, 8'h80, 8'h80, 0, 0, "R1");
    doOp(13, 8'h5A, 0, 1, 1, "R8");
    // R9 carry operations
    doOp(14, 8'h33, 0, 0, 0, "R9");
    doOp(15, 8'h33, 0, 1, 0, "R9");
    doOp(15, 8'h33, 0, 0, 0, "R9");
    idleCheck();
    idleCheck();

    // exhaustive add / add with carry (R1)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        doOp(((a + b) % 2 == 1) ? 1 : 0, a, b, ((a / 8) + b) % 2, 0, "R1");

    // exhaustive decimal adjust over acIn and cyIn (R7)
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++)
        doOp(12, a, 0, k % 2, k / 2, "R7");

    // mixed random operations with idle gaps (R10 hold behaviour)
    for (int n = 0; n < 800; n++) begin
      if (n % 7 == 3) idleCheck();
      else doOp(int'($urandom_range(15)), int'($urandom_range(255)), int'($urandom_range(255)),
                int'($urandom_range(1)), int'($urandom_range(1)), "");
    end

    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule